// File: doc/BRIEF.md
# Cascadable Signed Multiply-Accumulate Slice

This block is one DSP slice for a signal-processing datapath. A signed 18x18 multiplier feeds a 41-bit adder/subtractor. The second addend is picked from three sources, each optionally given an arithmetic right shift of 17 places first:
- the slice's own registered result, for accumulation;
- a preset constant, to start an accumulation;
- the result of a neighbouring slice, passed in on the cascade input.

The shifted cascade path lets several slices combine partial products into a wider multiply. Chains of slices wired output to input build filter and transform structures.

The slice has two further modes. The product can skip the adder and go straight into the output register. The multiplier can also be split into two independent signed 9x9 multipliers whose products are packed side by side in the result.

The result and an overflow flag are registered together. The output register has a clock enable, a synchronous clear and an asynchronous reset. The registered result also leaves the slice on the cascade output for the next slice in a chain.

Top module: `mac_slice`

## Requirements
- R1: When `bypass`=1 and `split`=0, an enabled cycle loads `acc_out` with the signed product `op_a*op_b`, sign-extended to 41 bits, and `ovfl` reads 0.
- R2: When `split`=1, an enabled cycle ignores `bypass` and the adder. `acc_out[17:0]` becomes `op_a[8:0]*op_b[8:0]` and `acc_out[35:18]` becomes `op_a[17:9]*op_b[17:9]`, both signed 9-bit by 9-bit. Bits `acc_out[40:36]` repeat bit 35, and `ovfl` reads 0.
- R3: With `split`=0 and `bypass`=0, `subtract`=0 loads operand + product and `subtract`=1 loads operand − product. The arithmetic is 41-bit two's complement and wraps.
- R4: The operand is `const_in` when `use_const`=1, whatever `use_casc` is. It is `casc_in` when `use_const`=0 and `use_casc`=1. When both are 0 it is the current `acc_out`.
- R5: When `shift17`=1, the selected operand is shifted right arithmetically by 17 bits, copying the sign bit, before the add or subtract.
- R6: `ovfl` is 1 exactly when the exact signed sum or difference of R3 does not fit in 41 bits. It is registered in the same cycle as the result it belongs to.
- R7: While `en`=0 and `clr`=0, `acc_out` and `ovfl` keep their values, whatever the other inputs do.
- R8: `clr`=1 zeroes `acc_out` and `ovfl` at the next clock edge, whatever `en` is. `rst_n`=0 zeroes them at once.
- R9: `casc_out` always equals `acc_out`.
- R10: A result appears on `acc_out` at the first rising clock edge after its inputs are applied, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock enable of the output register |
| clr | input | 1 | Synchronous clear, overrides `en` |
| op_a | input | 18 | Signed multiplicand; two signed 9-bit halves in split mode |
| op_b | input | 18 | Signed multiplier; two signed 9-bit halves in split mode |
| split | input | 1 | 1 selects the dual 9x9 mode |
| bypass | input | 1 | 1 sends the product straight to the register |
| subtract | input | 1 | 1 subtracts the product from the operand |
| use_const | input | 1 | Selects `const_in` as the operand (highest priority) |
| use_casc | input | 1 | Selects `casc_in` as the operand |
| shift17 | input | 1 | Arithmetic right shift of the operand by 17 |
| const_in | input | 41 | Preset operand value |
| casc_in | input | 41 | Result of the previous slice |
| acc_out | output | 41 | Registered result |
| ovfl | output | 1 | Registered signed overflow flag |
| casc_out | output | 41 | Copy of the result for the next slice |

## Verification
On every cycle the assertions check four things:
- An enabled split or bypass cycle never raises the overflow flag.
- A split result's top five bits repeat bit 35.
- The register holds while it is disabled, and a clear empties it.
- An overflow during plain accumulation always flips the sign of the result.

Only the bench's scenarios can show the rest: the exact arithmetic values, the operand priority with both selects high, the arithmetic shift of negative cascade values, and overflow at the positive and negative ends of the range. A behavioural reference model works these out with exact 64-bit integer arithmetic and checks every clock, through directed cases and a run of random control patterns.

// File: rtl/mac_pkg.sv
package mac_pkg;
   // Source of the second addend
   typedef enum logic [1:0] {
      SRC_FEEDBACK = 2'd0,
      SRC_PRESET   = 2'd1,
      SRC_CHAIN    = 2'd2
   } addend_src_e;

   // Result routing into the output register
   typedef enum logic [1:0] {
      ROUTE_ARITH  = 2'd0,
      ROUTE_DIRECT = 2'd1,
      ROUTE_DUAL   = 2'd2
   } route_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
   parameter int OP_W = 18
) (
   input  logic [OP_W-1:0]          op_a,
   input  logic [OP_W-1:0]          op_b,
   output logic signed [2*OP_W-1:0] prod_full,
   output logic signed [OP_W-1:0]   prod_lo,
   output logic signed [OP_W-1:0]   prod_hi
);
   localparam int HALF_W = OP_W / 2;

   generate
      if ((OP_W % 2) != 0) begin : g_bad_width
         $error("mac_mult: OP_W must be even");
      end
   endgenerate

   assign prod_full = $signed(op_a) * $signed(op_b);

   logic signed [OP_W-1:0] lane_prod [2];

   // One narrow signed multiplier per operand half
   generate
      for (genvar g = 0; g < 2; g++) begin : g_lane
         logic signed [HALF_W-1:0] la;
         logic signed [HALF_W-1:0] lb;
         assign la = op_a[g*HALF_W +: HALF_W];
         assign lb = op_b[g*HALF_W +: HALF_W];
         assign lane_prod[g] = la * lb;
      end
   endgenerate

   assign prod_lo = lane_prod[0];
   assign prod_hi = lane_prod[1];
endmodule

// File: rtl/mac_opsel.sv
module mac_opsel
   import mac_pkg::*;
#(
   parameter int ACC_W     = 41,
   parameter int SHIFT_AMT = 17
) (
   input  logic                    use_const,
   input  logic                    use_casc,
   input  logic                    shift_en,
   input  logic [ACC_W-1:0]        const_in,
   input  logic [ACC_W-1:0]        casc_in,
   input  logic [ACC_W-1:0]        fb_in,
   output logic signed [ACC_W-1:0] operand
);
   generate
      if (SHIFT_AMT < 0 || SHIFT_AMT >= ACC_W) begin : g_bad_shift
         $error("mac_opsel: SHIFT_AMT out of range");
      end
   endgenerate

   addend_src_e            src;
   logic signed [ACC_W-1:0] picked;

   // Fixed priority: preset over chain over feedback
   always_comb begin
      if (use_const)     src = SRC_PRESET;
      else if (use_casc) src = SRC_CHAIN;
      else               src = SRC_FEEDBACK;
   end

   always_comb begin
      unique case (src)
         SRC_PRESET: picked = $signed(const_in);
         SRC_CHAIN:  picked = $signed(casc_in);
         default:    picked = $signed(fb_in);
      endcase
   end

   generate
      if (SHIFT_AMT == 0) begin : g_noshift
         logic unused_shift;
         assign unused_shift = shift_en;
         assign operand = picked;
      end else begin : g_shift
         assign operand = shift_en ? (picked >>> SHIFT_AMT) : picked;
      end
   endgenerate
endmodule

// File: rtl/mac_addsub.sv
module mac_addsub #(
   parameter int ACC_W = 41
) (
   input  logic signed [ACC_W-1:0] operand,
   input  logic signed [ACC_W-1:0] product,
   input  logic                    subtract,
   output logic signed [ACC_W-1:0] result,
   output logic                    wrapped
);
   localparam int MSB = ACC_W - 1;

   logic signed [ACC_W-1:0] addend;

   // Product width is well below ACC_W, so negation never overflows
   assign addend = subtract ? (~product + 1'b1) : product;
   assign result = operand + addend;

   always_comb begin
      wrapped = (operand[MSB] == addend[MSB]) && (result[MSB] != operand[MSB]);
   end
endmodule

// File: rtl/mac_slice.sv
module mac_slice
   import mac_pkg::*;
#(
   parameter int OP_W      = 18,
   parameter int ACC_W     = 41,
   parameter int SHIFT_AMT = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic [OP_W-1:0]  op_a,
   input  logic [OP_W-1:0]  op_b,
   input  logic             split,
   input  logic             bypass,
   input  logic             subtract,
   input  logic             use_const,
   input  logic             use_casc,
   input  logic             shift17,
   input  logic [ACC_W-1:0] const_in,
   input  logic [ACC_W-1:0] casc_in,
   output logic [ACC_W-1:0] acc_out,
   output logic             ovfl,
   output logic [ACC_W-1:0] casc_out
);
   localparam int PROD_W = 2 * OP_W;
   localparam int EXT_W  = ACC_W - PROD_W;

   generate
      if (EXT_W < 1) begin : g_bad_acc
         $error("mac_slice: ACC_W must exceed twice OP_W");
      end
   endgenerate

   logic signed [PROD_W-1:0] prod_full;
   logic signed [OP_W-1:0]   prod_lo;
   logic signed [OP_W-1:0]   prod_hi;
   logic signed [ACC_W-1:0]  prod_ext;
   logic signed [ACC_W-1:0]  operand;
   logic signed [ACC_W-1:0]  arith_res;
   logic                     arith_wrap;
   logic [ACC_W-1:0]         dual_word;
   logic [ACC_W-1:0]         next_acc;
   logic                     next_ovfl;
   route_e                   route;

   mac_mult #(.OP_W(OP_W)) u_mult (
      .op_a      (op_a),
      .op_b      (op_b),
      .prod_full (prod_full),
      .prod_lo   (prod_lo),
      .prod_hi   (prod_hi)
   );

   assign prod_ext  = {{EXT_W{prod_full[PROD_W-1]}}, prod_full};
   assign dual_word = {{EXT_W{prod_hi[OP_W-1]}}, prod_hi, prod_lo};

   mac_opsel #(.ACC_W(ACC_W), .SHIFT_AMT(SHIFT_AMT)) u_opsel (
      .use_const (use_const),
      .use_casc  (use_casc),
      .shift_en  (shift17),
      .const_in  (const_in),
      .casc_in   (casc_in),
      .fb_in     (acc_out),
      .operand   (operand)
   );

   mac_addsub #(.ACC_W(ACC_W)) u_addsub (
      .operand  (operand),
      .product  (prod_ext),
      .subtract (subtract),
      .result   (arith_res),
      .wrapped  (arith_wrap)
   );

   always_comb begin
      if (split)       route = ROUTE_DUAL;
      else if (bypass) route = ROUTE_DIRECT;
      else             route = ROUTE_ARITH;
   end

   always_comb begin
      unique case (route)
         ROUTE_DUAL: begin
            next_acc  = dual_word;
            next_ovfl = 1'b0;
         end
         ROUTE_DIRECT: begin
            next_acc  = prod_ext;
            next_ovfl = 1'b0;
         end
         default: begin
            next_acc  = arith_res;
            next_ovfl = arith_wrap;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_out <= '0;
         ovfl    <= 1'b0;
      end else if (clr) begin
         acc_out <= '0;
         ovfl    <= 1'b0;
      end else if (en) begin
         acc_out <= next_acc;
         ovfl    <= next_ovfl;
      end
   end

   assign casc_out = acc_out;
endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk #(
   parameter int OP_W  = 18,
   parameter int ACC_W = 41
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             clr,
   input logic             split,
   input logic             bypass,
   input logic             use_const,
   input logic             use_casc,
   input logic             shift17,
   input logic [ACC_W-1:0] acc_out,
   input logic             ovfl
);
   localparam int TOP   = 2 * OP_W;
   localparam int EXT_W = ACC_W - TOP;

   AST_SPLIT_NO_OVFL: assert property (@(posedge clk) disable iff (!rst_n)
      (en && split && !clr) |=> !ovfl); // R2

   AST_SPLIT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (en && split && !clr) |=> (acc_out[ACC_W-1:TOP] == {EXT_W{acc_out[TOP-1]}})); // R2

   AST_BYPASS_NO_OVFL: assert property (@(posedge clk) disable iff (!rst_n)
      (en && bypass && !clr) |=> !ovfl); // R1

   AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> ($stable(acc_out) && $stable(ovfl))); // R7

   AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_out == '0 && !ovfl)); // R8

   AST_OVFL_FLIPS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && !split && !bypass && !use_const && !use_casc && !shift17)
      |=> (!ovfl || (acc_out[ACC_W-1] != $past(acc_out[ACC_W-1])))); // R6
endmodule

bind mac_slice mac_slice_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .clr       (clr),
   .split     (split),
   .bypass    (bypass),
   .use_const (use_const),
   .use_casc  (use_casc),
   .shift17   (shift17),
   .acc_out   (acc_out),
   .ovfl      (ovfl)
);

// File: tb/tb_mac_slice.sv
module tb_mac_slice;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en, clr, split, bypass, subtract, use_const, use_casc, shift17;
   logic [17:0] op_a, op_b;
   logic [40:0] const_in, casc_in;
   logic [40:0] acc_out, casc_out;
   logic        ovfl;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   logic [40:0] exp_acc = '0;
   logic        exp_ovf = 1'b0;

   always #5 clk = ~clk;

   mac_slice dut (
      .clk(clk), .rst_n(rst_n), .en(en), .clr(clr),
      .op_a(op_a), .op_b(op_b), .split(split), .bypass(bypass),
      .subtract(subtract), .use_const(use_const), .use_casc(use_casc),
      .shift17(shift17), .const_in(const_in), .casc_in(casc_in),
      .acc_out(acc_out), .ovfl(ovfl), .casc_out(casc_out)
   );

   function automatic longint sext41(input longint x);
      logic [40:0] t;
      t = x[40:0];
      return longint'({{23{t[40]}}, t});
   endfunction

   // Behavioural reference: exact integer arithmetic, then wrap test
   task automatic model_edge();
      longint pa, pb, prod, op, sum, p1, p2, v;
      if (clr) begin
         exp_acc = '0; exp_ovf = 1'b0;
      end else if (en) begin
         if (split) begin
            p1 = longint'($signed(op_a[8:0])) * longint'($signed(op_b[8:0]));
            p2 = longint'($signed(op_a[17:9])) * longint'($signed(op_b[17:9]));
            v = p2 * 262144 + (p1 & 64'h3FFFF);
            exp_acc = v[40:0]; exp_ovf = 1'b0;
         end else begin
            pa = longint'($signed(op_a));
            pb = longint'($signed(op_b));
            prod = pa * pb;
            if (bypass) begin
               exp_acc = prod[40:0]; exp_ovf = 1'b0;
            end else begin
               if (use_const)     op = sext41({23'b0, const_in});
               else if (use_casc) op = sext41({23'b0, casc_in});
               else               op = sext41({23'b0, exp_acc});
               if (shift17) op = op >>> 17;
               sum = subtract ? (op - prod) : (op + prod);
               exp_acc = sum[40:0];
               exp_ovf = (sext41(sum) != sum);
            end
         end
      end
   endtask

   task automatic check(input string tag);
      checks++;
      if (acc_out !== exp_acc || ovfl !== exp_ovf) begin
         errors++;
         $display("FAIL %s: acc_out=%h ovfl=%b expected acc_out=%h ovfl=%b",
                  tag, acc_out, ovfl, exp_acc, exp_ovf);
      end
      checks++;
      if (casc_out !== acc_out) begin
         errors++;
         $display("FAIL R9: casc_out=%h expected %h", casc_out, acc_out);
      end
   endtask

   task automatic idle();
      en = 1'b1; clr = 1'b0; split = 1'b0; bypass = 1'b0; subtract = 1'b0;
      use_const = 1'b0; use_casc = 1'b0; shift17 = 1'b0;
      op_a = '0; op_b = '0; const_in = '0; casc_in = '0;
   endtask

   // Inputs are set after a falling edge; one rising edge; compare at next falling edge (R10)
   task automatic step(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      idle();
      en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 reset state");

      // R1 / R10: bypass products
      idle(); bypass = 1'b1;
      op_a = 18'd3; op_b = 18'd5;                        step("R1 3*5");
      op_a = -18'sd7; op_b = 18'd9;                      step("R1 -7*9");
      op_a = 18'h20000; op_b = 18'h20000;                step("R1 min*min");
      op_a = 18'h1FFFF; op_b = 18'h20000;                step("R10 max*min");

      // R4 / R3: preset then accumulate and subtract
      idle(); use_const = 1'b1; const_in = 41'd100; op_a = 18'd2; op_b = 18'd3;
      step("R4 preset 100+6");
      idle(); op_a = 18'd4; op_b = 18'd5;                step("R3 feedback add");
      idle(); subtract = 1'b1; op_a = 18'd1; op_b = 18'd6; step("R3 feedback subtract");
      idle(); subtract = 1'b1; op_a = -18'sd50; op_b = 18'd50; step("R3 subtract negative product");

      // R4 priority
      idle(); use_const = 1'b1; use_casc = 1'b1; const_in = 41'd7; casc_in = 41'd1000;
      op_a = 18'd1; op_b = 18'd1;                         step("R4 const over casc");
      idle(); use_casc = 1'b1; casc_in = 41'h1_2345_6789; op_a = 18'd2; op_b = 18'd2;
      step("R4 casc select");

      // R5 shift
      idle(); use_casc = 1'b1; shift17 = 1'b1; casc_in = 41'd1 << 30; op_a = 18'd1; op_b = 18'd1;
      step("R5 positive shift");
      idle(); use_casc = 1'b1; shift17 = 1'b1; casc_in = -(41'd1 << 30) - 41'd5;
      step("R5 negative shift sign fill");
      idle(); shift17 = 1'b1; op_a = 18'd3; op_b = 18'd3;  step("R5 shift of feedback");

      // R6 overflow at both ends
      idle(); use_const = 1'b1; const_in = {1'b0, {40{1'b1}}}; op_a = 18'd1; op_b = 18'd1;
      step("R6 positive wrap");
      idle(); use_const = 1'b1; const_in = {1'b1, 40'b0}; subtract = 1'b1; op_a = 18'd1; op_b = 18'd1;
      step("R6 negative wrap");
      idle(); use_const = 1'b1; const_in = {1'b1, 40'b0}; op_a = 18'd1; op_b = 18'd1;
      step("R6 no wrap clears flag");
      idle(); use_const = 1'b1; const_in = {1'b0, {40{1'b1}}}; op_a = 18'd1; op_b = 18'd1;
      step("R6 wrap again");
      idle(); bypass = 1'b1; op_a = 18'd2; op_b = 18'd2;  step("R6 bypass clears flag");

      // R2 split
      idle(); split = 1'b1; op_a = {9'h1FD, 9'd5}; op_b = {9'd7, 9'h1FE};
      step("R2 split mixed signs");
      idle(); split = 1'b1; bypass = 1'b1; op_a = {9'h100, 9'h100}; op_b = {9'h100, 9'd255};
      step("R2 split extremes");
      idle(); split = 1'b1; use_const = 1'b1; const_in = {1'b0, {40{1'b1}}};
      op_a = {9'd3, 9'd4}; op_b = {9'd5, 9'd6};           step("R2 split ignores adder");

      // R7 hold
      idle(); use_const = 1'b1; const_in = 41'd12345; step("R7 load");
      idle(); en = 1'b0; bypass = 1'b1; op_a = 18'd99; op_b = 18'd99; step("R7 hold bypass");
      idle(); en = 1'b0; split = 1'b1; op_a = 18'h3FFFF;   step("R7 hold split");
      idle(); use_const = 1'b1; const_in = {1'b0, {40{1'b1}}}; op_a = 18'd1; op_b = 18'd1;
      step("R7 load overflow");
      idle(); en = 1'b0; op_a = 18'd1; op_b = 18'd1;       step("R7 hold overflow flag");

      // R8 clear wins over disabled enable
      idle(); en = 1'b0; clr = 1'b1;                      step("R8 clear with en low");
      idle(); use_const = 1'b1; const_in = 41'd77;        step("R8 reload");
      idle(); clr = 1'b1; bypass = 1'b1; op_a = 18'd5; op_b = 18'd5; step("R8 clear with en high");

      // Random control patterns
      for (int i = 0; i < 400; i++) begin
         en = ($urandom_range(0, 7) != 0);
         clr = ($urandom_range(0, 31) == 0);
         split = ($urandom_range(0, 5) == 0);
         bypass = ($urandom_range(0, 5) == 0);
         subtract = $urandom_range(0, 1) != 0;
         use_const = ($urandom_range(0, 5) == 0);
         use_casc = ($urandom_range(0, 3) == 0);
         shift17 = ($urandom_range(0, 3) == 0);
         op_a = 18'($urandom);
         op_b = 18'($urandom);
         const_in = {9'($urandom), 32'($urandom)};
         casc_in = {9'($urandom), 32'($urandom)};
         step("R3 R4 R5 R6 random");
      end

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule